// File: doc/BRIEF.md
# SPD Image CRC-16 Checker

This block checks the integrity of a 128-byte serial-presence-detect image while the image streams past, one byte on each cycle that carries a valid strobe. A start pulse opens a stream. Each byte that falls inside the covered range is folded into a 16-bit CRC register in a single clock. The last two bytes of the image carry the stored CRC, and the block latches them. After the final byte it raises a one-cycle completion pulse, together with a pass/fail flag.

The length of the covered range is not fixed. It is taken from the top bit of the first byte of the stream, so the same hardware handles images that protect either the short or the long range. A failed comparison changes only the pass flag. The stream is always accepted in full, and any later decoding can still proceed. A fresh start pulse can abandon a stream at any point. The running count of accepted bytes is brought out so that the producer can track its position in the image.

Top module: `spd_crc_checker`

## Requirements
- R1: After reset, done, crc_ok, crc_value and next_idx are all zero.
- R2: For each covered byte, the CRC register is first XORed with the byte in bits 15:8. It then takes eight MSB-first shift steps, and each step XORs 0x1021 into the result when the bit shifted out of bit 15 was 1. The register starts each stream at 0x0000, and crc_value shows the new value in the cycle after the byte is accepted.
- R3: When bit 7 of byte 0 is 1, only bytes 0 to 116 (117 bytes) are covered.
- R4: When bit 7 of byte 0 is 0, bytes 0 to 125 (126 bytes) are covered.
- R5: The stored CRC has byte 127 as its upper 8 bits and byte 126 as its lower 8 bits. crc_ok is 1 in the done cycle exactly when the stored CRC equals the computed CRC, and crc_ok is 0 in every other cycle.
- R6: done is high for exactly one cycle: the cycle after byte 127 is accepted.
- R7: A byte outside the covered range advances next_idx and leaves crc_value unchanged.
- R8: A start pulse clears crc_value and next_idx to zero in the next cycle. A start pulse in the middle of a stream abandons that stream, and no done is raised for it.
- R9: byte_valid has no effect when no stream is open, that is, before the first start or after byte 127 of a stream. Outside a stream, crc_value and next_idx hold and done stays low.
- R10: A byte presented in the same cycle as start is discarded. The next accepted byte is byte 0.
- R11: next_idx equals the number of bytes accepted in the current stream, modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new stream and clears the CRC and the byte count |
| byte_valid | input | 1 | byte_data carries an image byte in this cycle |
| byte_data | input | 8 | Image byte |
| done | output | 1 | One-cycle pulse after the last image byte |
| crc_ok | output | 1 | Stored CRC matched the computed CRC; valid only while done is high |
| crc_value | output | 16 | Current value of the CRC register |
| next_idx | output | 7 | Index of the next byte expected (count of bytes accepted) |

## Verification
Some properties are checked by the assertions on every cycle. done must be a single-cycle pulse that follows the acceptance of the final byte, and crc_ok may appear only alongside done. A start must leave a cleared register and count. Bytes beyond the covered range, and bytes arriving outside an open stream, must leave the CRC untouched. Other behaviour can only be shown by the bench scenarios: the CRC arithmetic itself, the choice of coverage length from byte 0, the byte order of the stored CRC, and which corruptions are caught. The bench sweeps every value of byte 0 and tampers with bytes on both sides of each coverage boundary.

// File: rtl/spd_crc_pkg.sv
package spd_crc_pkg;

  // Classification of the current beat, produced by the sequencer.
  typedef struct packed {
    logic accept;   // byte is taken into the open stream
    logic covered;  // byte contributes to the CRC
    logic ref_lo;   // byte is the low half of the stored CRC
    logic ref_hi;   // byte is the high half of the stored CRC (last byte)
  } beat_t;

  // One MSB-first shift step of the CRC register.
  function automatic logic [15:0] crc_shift1(input logic [15:0] r,
                                             input logic [15:0] poly);
    logic [15:0] nxt;
    nxt = {r[14:0], 1'b0};
    if (r[15]) nxt = nxt ^ poly;
    return nxt;
  endfunction

endpackage

// File: rtl/spd_crc_sequencer.sv
module spd_crc_sequencer
  import spd_crc_pkg::*;
#(
  parameter int IMG_BYTES   = 128,
  parameter int COVER_SHORT = 117,
  parameter int COVER_LONG  = 126,
  localparam int IDX_W = $clog2(IMG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             byte_valid,
  input  logic             len_flag,
  output logic             active,
  output logic [IDX_W-1:0] cnt,
  output beat_t            beat
);

  localparam int LAST_IDX = IMG_BYTES - 1;
  localparam int LO_IDX   = IMG_BYTES - 2;

  logic short_q;
  logic is_first;
  logic short_now;
  int   limit;

  always_comb begin
    is_first     = (cnt == '0);
    short_now    = is_first ? len_flag : short_q;
    limit        = short_now ? COVER_SHORT : COVER_LONG;
    beat.accept  = active & byte_valid & ~start;
    beat.covered = (int'(cnt) < limit);
    beat.ref_lo  = (int'(cnt) == LO_IDX);
    beat.ref_hi  = (int'(cnt) == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      short_q <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      cnt     <= '0;
      short_q <= 1'b0;
    end else if (beat.accept) begin
      cnt <= beat.ref_hi ? '0 : cnt + 1'b1;
      if (is_first) short_q <= len_flag;
      if (beat.ref_hi) active <= 1'b0;
    end
  end

endmodule

// File: rtl/spd_crc_engine.sv
module spd_crc_engine
  import spd_crc_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'h0000,
  parameter int          DATA_W = 8,
  localparam int         CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_en,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] stage [0:DATA_W];

  assign stage[0] = crc ^ {data, {(CRC_W-DATA_W){1'b0}}};

  for (genvar k = 0; k < DATA_W; k++) begin : g_step
    assign stage[k+1] = crc_shift1(stage[k], POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc <= SEED;
    else if (clear)   crc <= SEED;
    else if (step_en) crc <= stage[DATA_W];
  end

endmodule

// File: rtl/spd_crc_refcap.sv
module spd_crc_refcap #(
  parameter int DATA_W = 8,
  localparam int CRC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic [DATA_W-1:0] data,
  input  logic [CRC_W-1:0]  crc_in,
  output logic              done,
  output logic              ok
);

  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      done <= 1'b0;
      ok   <= 1'b0;
    end else begin
      done <= 1'b0;
      ok   <= 1'b0;
      if (clear) begin
        lo_q <= '0;
      end else begin
        if (cap_lo) lo_q <= data;
        if (cap_hi) begin
          done <= 1'b1;
          ok   <= ({data, lo_q} == crc_in);
        end
      end
    end
  end

endmodule

// File: rtl/spd_crc_checker.sv
module spd_crc_checker
  import spd_crc_pkg::*;
#(
  parameter int          IMG_BYTES   = 128,
  parameter int          COVER_SHORT = 117,
  parameter int          COVER_LONG  = 126,
  parameter int          FLAG_BIT    = 7,
  parameter logic [15:0] POLY        = 16'h1021,
  parameter logic [15:0] SEED        = 16'h0000,
  localparam int         IDX_W       = $clog2(IMG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             done,
  output logic             crc_ok,
  output logic [15:0]      crc_value,
  output logic [IDX_W-1:0] next_idx
);

  beat_t beat;
  logic  active;

  // Named events for the checker.
  logic byte_accept;
  logic cover_hit;
  logic last_accept;

  spd_crc_sequencer #(
    .IMG_BYTES  (IMG_BYTES),
    .COVER_SHORT(COVER_SHORT),
    .COVER_LONG (COVER_LONG)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .byte_valid(byte_valid),
    .len_flag  (byte_data[FLAG_BIT]),
    .active    (active),
    .cnt       (next_idx),
    .beat      (beat)
  );

  assign byte_accept = beat.accept;
  assign cover_hit   = beat.accept & beat.covered;
  assign last_accept = beat.accept & beat.ref_hi;

  spd_crc_engine #(
    .POLY  (POLY),
    .SEED  (SEED),
    .DATA_W(8)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .step_en(cover_hit),
    .data   (byte_data),
    .crc    (crc_value)
  );

  spd_crc_refcap #(
    .DATA_W(8)
  ) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .cap_lo(beat.accept & beat.ref_lo),
    .cap_hi(last_accept),
    .data  (byte_data),
    .crc_in(crc_value),
    .done  (done),
    .ok    (crc_ok)
  );

endmodule

// File: rtl/spd_crc_checker_sva.sv
module spd_crc_checker_sva #(
  parameter int          IDX_W = 7,
  parameter logic [15:0] SEED  = 16'h0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             active,
  input logic             byte_accept,
  input logic             cover_hit,
  input logic             last_accept,
  input logic             done,
  input logic             crc_ok,
  input logic [15:0]      crc_value,
  input logic [IDX_W-1:0] next_idx
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last_accept)); // R6

  AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> done); // R5

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (crc_value == SEED && next_idx == '0 && !done)); // R8

  AST_UNCOVERED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_accept && !cover_hit) |=> $stable(crc_value)); // R7

  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> ($stable(crc_value) && $stable(next_idx) && !done)); // R9

endmodule

bind spd_crc_checker spd_crc_checker_sva #(
  .IDX_W(IDX_W),
  .SEED (SEED)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .active     (active),
  .byte_accept(byte_accept),
  .cover_hit  (cover_hit),
  .last_accept(last_accept),
  .done       (done),
  .crc_ok     (crc_ok),
  .crc_value  (crc_value),
  .next_idx   (next_idx)
);

// File: tb/test_spd_crc_checker.sv
module test_spd_crc_checker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       done;
  logic       crc_ok;
  logic [15:0] crc_value;
  logic [6:0] next_idx;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] img [128];
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  spd_crc_checker i_spd_crc_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .done(done), .crc_ok(crc_ok),
    .crc_value(crc_value), .next_idx(next_idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bitwise model: feed data bits one at a time, MSB first.
  function automatic logic [15:0] model_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic int cover_len();
    return img[0][7] ? 117 : 126;
  endfunction

  function automatic logic [15:0] model_crc();
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < cover_len(); i++) c = model_step(c, img[i]);
    return c;
  endfunction

  task automatic seal();
    logic [15:0] c = model_crc();
    img[126] = c[7:0];
    img[127] = c[15:8];
  endtask

  function automatic logic [7:0] rnd8();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[7:0];
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    byte_valid = 1'b1; byte_data = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic run_image(input bit do_start, input bit expect_ok, input bit trace);
    logic [15:0] run = 16'h0000;
    int cov = cover_len();
    if (do_start) begin
      pulse_start();
      chk(next_idx == 0 && crc_value == 0, "R8", "cleared after start",
          {crc_value, 9'd0, next_idx}, 0);
    end
    for (int i = 0; i < 128; i++) begin
      send(img[i]);
      if (i < cov) run = model_step(run, img[i]);
      if (trace) begin
        chk(crc_value == run, (i < cov) ? "R2" : "R7", "running crc", crc_value, run);
        chk(next_idx == 7'((i + 1) % 128), "R11", "byte count", next_idx, (i + 1) % 128);
        if (i < 127) chk(done == 0, "R6", "done early", done, 0);
      end
    end
    chk(done == 1, "R6", "done after last byte", done, 1);
    chk(crc_ok == expect_ok, "R5", "crc_ok", crc_ok, expect_ok);
    chk(crc_value == run, cov == 117 ? "R3" : "R4", "final crc", crc_value, run);
    @(negedge clk);
    chk(done == 0 && crc_ok == 0, "R6", "done single cycle", {done, crc_ok}, 0);
  endtask

  task automatic fill_random(input bit short_mode);
    for (int i = 0; i < 128; i++) img[i] = rnd8();
    img[0][7] = short_mode;
    seal();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 0 && crc_ok == 0 && crc_value == 0 && next_idx == 0, "R1", "reset state",
        {done, crc_ok, crc_value, next_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: bytes before any start are ignored
    for (int i = 0; i < 4; i++) begin
      send(8'hA5 + 8'(i));
      chk(crc_value == 0 && next_idx == 0 && done == 0, "R9", "pre-start byte",
          {crc_value, next_idx, done}, 0);
    end

    // R3/R4: sweep every value of byte 0
    for (int b = 0; b < 256; b++) begin
      for (int i = 1; i < 128; i++) img[i] = 8'(i * 7 + b);
      img[0] = 8'(b);
      seal();
      run_image(1, 1, b < 3 || b == 128 || b == 255);
    end

    // R2: random images in both modes, traced
    for (int n = 0; n < 16; n++) begin
      fill_random(n[0]);
      run_image(1, 1, 1);
    end

    // R3: short mode ignores bytes 117..125
    fill_random(1);
    img[120] = img[120] ^ 8'h5A;
    run_image(1, 1, 0);
    fill_random(1);
    img[117] = img[117] ^ 8'h01;
    run_image(1, 1, 0);
    fill_random(1);
    img[116] = img[116] ^ 8'h01;
    run_image(1, 0, 0);
    // R4: long mode covers up to byte 125
    fill_random(0);
    img[120] = img[120] ^ 8'h5A;
    run_image(1, 0, 0);
    fill_random(0);
    img[125] = img[125] ^ 8'h80;
    run_image(1, 0, 0);

    // R5: stored CRC corruption and byte order
    fill_random(0);
    img[127] = img[127] ^ 8'h10;
    run_image(1, 0, 0);
    fill_random(1);
    img[126] = img[126] ^ 8'h01;
    run_image(1, 0, 0);
    fill_random(0);
    while (img[126] == img[127]) fill_random(0);
    begin
      logic [7:0] t = img[126];
      img[126] = img[127];
      img[127] = t;
    end
    run_image(1, 0, 0);

    // R8: restart mid-stream, no done for the abandoned stream
    fill_random(0);
    pulse_start();
    for (int i = 0; i < 60; i++) begin
      send(img[i]);
      chk(done == 0, "R8", "no done mid stream", done, 0);
    end
    run_image(1, 1, 1);

    // R9: bytes after the last byte are ignored
    held = crc_value;
    for (int i = 0; i < 5; i++) begin
      send(8'h3C);
      chk(crc_value == held && next_idx == 0 && done == 0, "R9", "post-stream byte",
          {crc_value, next_idx, done}, {held, 7'd0, 1'b0});
    end

    // R10: byte together with start is discarded
    fill_random(1);
    @(negedge clk);
    start = 1'b1; byte_valid = 1'b1; byte_data = 8'hFF;
    @(negedge clk);
    start = 1'b0; byte_valid = 1'b0;
    chk(next_idx == 0 && crc_value == 0, "R10", "byte with start dropped",
        {crc_value, 9'd0, next_idx}, 0);
    run_image(0, 1, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule